// File: doc/BRIEF.md
# Trap and Return Exception Controller

This block owns the exception-related system state of a 32-bit core: the status word, the saved-PC/saved-status pair used by ordinary exceptions, a second saved pair reserved for the non-maskable interrupt, and an exception cause word. The core's decoder reports, one cycle at a time, whether the current instruction is a software trap (with a 5-bit vector and its own address), a return-from-exception, or an interrupt disable/enable. Separately, the interrupt logic can raise a non-maskable entry request carrying the PC to resume at.

For every trap, return and non-maskable entry the block updates its registers. In the following cycle it drives a redirect strobe and a target address for the fetch unit. A return picks one of the two saved pairs from two status bits. This lets a handler of an ordinary exception that runs inside a non-maskable handler return to the right place. Trap vectors are split between two fixed handler addresses.

Top module: `trap_ret_ctl`

## Requirements
- R1: On an accepted trap, the ordinary saved PC becomes the trap's PC plus 4, and the ordinary saved status becomes the status word as it was before the trap.
- R2: On an accepted trap, cause bits [15:0] become 0x40 plus the trap vector, and cause bits [31:16] keep their value.
- R3: On an accepted trap, status bit 6 (exception pending) and bit 5 (interrupt disable) are set, and all other status bits keep their value.
- R4: In the cycle after an accepted trap, the redirect strobe is high and the redirect address is 0x40 for vectors 0 to 15 and 0x50 for vectors 16 to 31.
- R5: On an accepted return with status bit 7 (NMI pending) set and bit 6 clear, the redirect address in the next cycle is the NMI saved PC, and the status word becomes the NMI saved status.
- R6: On an accepted return in every other status state, the redirect address in the next cycle is the ordinary saved PC, and the status word becomes the ordinary saved status.
- R7: The disable operation sets status bit 5 and the enable operation clears it. When both are requested in the same cycle, bit 5 is set.
- R8: A non-maskable entry stores its PC input in the NMI saved PC and the prior status in the NMI saved status. It sets status bits 7 and 5 and writes NMI_CODE (default 0x0010) to cause bits [31:16], keeping bits [15:0]. In the next cycle it redirects to NMI_ADDR (default 0x10).
- R9: Priority per cycle is non-maskable entry, then trap, then return, then disable/enable. A lower-priority request arriving with a higher one is ignored.
- R10: After reset, every saved register and the cause word are 0, the status word is 0x20 (only bit 5 set), and the redirect strobe is low.
- R11: The redirect strobe is high only in the cycle after a cycle that had a non-maskable entry, trap or return request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req_i | input | 1 | Non-maskable entry request |
| nmi_pc_i | input | 32 | PC to resume at after the non-maskable handler |
| trap_req_i | input | 1 | Trap instruction present |
| trap_vec_i | input | 5 | Trap vector |
| trap_pc_i | input | 32 | Address of the trap instruction |
| ret_req_i | input | 1 | Return-from-exception instruction present |
| irq_off_i | input | 1 | Disable maskable interrupts |
| irq_on_i | input | 1 | Enable maskable interrupts |
| psw_o | output | 32 | Status word |
| eipc_o | output | 32 | Ordinary saved PC |
| eipsw_o | output | 32 | Ordinary saved status |
| fepc_o | output | 32 | NMI saved PC |
| fepsw_o | output | 32 | NMI saved status |
| cause_o | output | 32 | Exception cause word |
| redir_vld_o | output | 1 | Redirect strobe |
| redir_pc_o | output | 32 | Redirect target address |

## Verification
Traps are issued with vectors 0, 15, 16 and 31, which separates the two handler addresses at their boundary and exposes any error in the cause sum. Returns are issued from three status states: after a plain trap, after a non-maskable entry, and after a trap nested inside a non-maskable handler. Together these show which saved pair the selection takes. Requests that collide in one cycle (trap with return, non-maskable entry with trap, disable with enable) confirm the priority order. A long stretch of random request mixes is then compared cycle by cycle against the bench's own model.

// File: rtl/trx_pkg.sv
package trx_pkg;
    localparam int XLEN    = 32;
    localparam int HALF    = XLEN / 2;
    localparam int PSW_ID  = 5;
    localparam int PSW_EP  = 6;
    localparam int PSW_NP  = 7;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_NMI,
        ACT_TRAP,
        ACT_RET,
        ACT_OFF,
        ACT_ON
    } trx_act_e;

    typedef struct packed {
        logic [XLEN-1:0] psw;
        logic [XLEN-1:0] eipc;
        logic [XLEN-1:0] eipsw;
        logic [XLEN-1:0] fepc;
        logic [XLEN-1:0] fepsw;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] rd_pc;
        logic            rd_vld;
    } trx_state_t;
endpackage

// File: rtl/trx_arbiter.sv
module trx_arbiter
    import trx_pkg::*;
(
    input  logic     nmi_req,
    input  logic     trap_req,
    input  logic     ret_req,
    input  logic     off_req,
    input  logic     on_req,
    output trx_act_e act
);
    // Fixed priority; disable wins over enable.
    always_comb begin
        if (nmi_req)       act = ACT_NMI;
        else if (trap_req) act = ACT_TRAP;
        else if (ret_req)  act = ACT_RET;
        else if (off_req)  act = ACT_OFF;
        else if (on_req)   act = ACT_ON;
        else               act = ACT_NONE;
    end
endmodule

// File: rtl/trx_vector_map.sv
module trx_vector_map #(
    parameter int          VEC_W      = 5,
    parameter int          ADDR_W     = 32,
    parameter int          CODE_W     = 16,
    parameter int          SPLIT      = 16,
    parameter logic [31:0] LO_ADDR    = 32'h40,
    parameter logic [31:0] HI_ADDR    = 32'h50,
    parameter logic [15:0] CAUSE_BASE = 16'h40
) (
    input  logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] handler,
    output logic [CODE_W-1:0] code
);
    localparam logic [VEC_W:0] SPLIT_V = (VEC_W+1)'(SPLIT);

    always_comb begin
        handler = ({1'b0, vec} < SPLIT_V) ? ADDR_W'(LO_ADDR) : ADDR_W'(HI_ADDR);
        code    = CODE_W'(CAUSE_BASE) + CODE_W'(vec);
    end
endmodule

// File: rtl/trx_return_sel.sv
module trx_return_sel
    import trx_pkg::*;
(
    input  logic [XLEN-1:0] psw,
    input  logic [XLEN-1:0] eipc,
    input  logic [XLEN-1:0] eipsw,
    input  logic [XLEN-1:0] fepc,
    input  logic [XLEN-1:0] fepsw,
    output logic            use_nmi_pair,
    output logic [XLEN-1:0] ret_pc,
    output logic [XLEN-1:0] ret_psw
);
    always_comb begin
        use_nmi_pair = psw[PSW_NP] & ~psw[PSW_EP];
        ret_pc       = use_nmi_pair ? fepc  : eipc;
        ret_psw      = use_nmi_pair ? fepsw : eipsw;
    end
endmodule

// File: rtl/trap_ret_ctl.sv
module trap_ret_ctl
    import trx_pkg::*;
#(
    parameter int          VEC_W    = 5,
    parameter logic [31:0] NMI_ADDR = 32'h10,
    parameter logic [15:0] NMI_CODE = 16'h0010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_req_i,
    input  logic [XLEN-1:0]  nmi_pc_i,
    input  logic             trap_req_i,
    input  logic [VEC_W-1:0] trap_vec_i,
    input  logic [XLEN-1:0]  trap_pc_i,
    input  logic             ret_req_i,
    input  logic             irq_off_i,
    input  logic             irq_on_i,
    output logic [XLEN-1:0]  psw_o,
    output logic [XLEN-1:0]  eipc_o,
    output logic [XLEN-1:0]  eipsw_o,
    output logic [XLEN-1:0]  fepc_o,
    output logic [XLEN-1:0]  fepsw_o,
    output logic [XLEN-1:0]  cause_o,
    output logic             redir_vld_o,
    output logic [XLEN-1:0]  redir_pc_o
);
    localparam logic [XLEN-1:0] PC_STEP   = XLEN'(4);
    localparam logic [XLEN-1:0] PSW_RESET = XLEN'(1) << PSW_ID;

    trx_state_t st_q, st_d;
    trx_act_e   act;
    logic [XLEN-1:0] trap_handler;
    logic [HALF-1:0] trap_code;
    logic            use_nmi_pair;
    logic [XLEN-1:0] ret_pc, ret_psw;

    trx_arbiter u_arb (
        .nmi_req (nmi_req_i),
        .trap_req(trap_req_i),
        .ret_req (ret_req_i),
        .off_req (irq_off_i),
        .on_req  (irq_on_i),
        .act     (act)
    );

    trx_vector_map #(
        .VEC_W (VEC_W),
        .ADDR_W(XLEN),
        .CODE_W(HALF)
    ) u_vmap (
        .vec    (trap_vec_i),
        .handler(trap_handler),
        .code   (trap_code)
    );

    trx_return_sel u_rsel (
        .psw         (st_q.psw),
        .eipc        (st_q.eipc),
        .eipsw       (st_q.eipsw),
        .fepc        (st_q.fepc),
        .fepsw       (st_q.fepsw),
        .use_nmi_pair(use_nmi_pair),
        .ret_pc      (ret_pc),
        .ret_psw     (ret_psw)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rd_vld = 1'b0;
        unique case (act)
            ACT_NMI: begin
                st_d.fepc             = nmi_pc_i;
                st_d.fepsw            = st_q.psw;
                st_d.psw[PSW_NP]      = 1'b1;
                st_d.psw[PSW_ID]      = 1'b1;
                st_d.cause[XLEN-1:HALF] = NMI_CODE;
                st_d.rd_vld           = 1'b1;
                st_d.rd_pc            = XLEN'(NMI_ADDR);
            end
            ACT_TRAP: begin
                st_d.eipc             = trap_pc_i + PC_STEP;
                st_d.eipsw            = st_q.psw;
                st_d.cause[HALF-1:0]  = trap_code;
                st_d.psw[PSW_EP]      = 1'b1;
                st_d.psw[PSW_ID]      = 1'b1;
                st_d.rd_vld           = 1'b1;
                st_d.rd_pc            = trap_handler;
            end
            ACT_RET: begin
                st_d.psw              = ret_psw;
                st_d.rd_vld           = 1'b1;
                st_d.rd_pc            = ret_pc;
            end
            ACT_OFF:  st_d.psw[PSW_ID] = 1'b1;
            ACT_ON:   st_d.psw[PSW_ID] = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.psw <= PSW_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign psw_o       = st_q.psw;
    assign eipc_o      = st_q.eipc;
    assign eipsw_o     = st_q.eipsw;
    assign fepc_o      = st_q.fepc;
    assign fepsw_o     = st_q.fepsw;
    assign cause_o     = st_q.cause;
    assign redir_vld_o = st_q.rd_vld;
    assign redir_pc_o  = st_q.rd_pc;

    logic trap_taken;
    assign trap_taken = trap_req_i & ~nmi_req_i;

    a_r1_save_pc: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> (eipc_o == $past(trap_pc_i) + 32'd4) && (eipsw_o == $past(psw_o)));

    a_r2_cause_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> cause_o[31:16] == $past(cause_o[31:16]));

    a_r3_ep_id_set: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> psw_o[PSW_EP] && psw_o[PSW_ID]);

    a_r4_handler: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> redir_vld_o &&
            (redir_pc_o == (($past(trap_vec_i) < 5'd16) ? 32'h40 : 32'h50)));

    a_r5_nmi_return: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req_i && !trap_req_i && !nmi_req_i && psw_o[PSW_NP] && !psw_o[PSW_EP])
        |=> redir_pc_o == $past(fepc_o) && psw_o == $past(fepsw_o));

    a_r6_exc_return: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req_i && !trap_req_i && !nmi_req_i && !(psw_o[PSW_NP] && !psw_o[PSW_EP]))
        |=> redir_pc_o == $past(eipc_o) && psw_o == $past(eipsw_o));

    a_r8_nmi_entry: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req_i |=> redir_vld_o && fepc_o == $past(nmi_pc_i) && psw_o[PSW_NP]);

    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_req_i || trap_req_i || ret_req_i) |=> !redir_vld_o);
endmodule

// File: tb/trap_ret_ctl_test.sv
module trap_ret_ctl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        nmi_req = 0, trap_req = 0, ret_req = 0, off_req = 0, on_req = 0;
    logic [31:0] nmi_pc = 0, trap_pc = 0;
    logic [4:0]  trap_vec = 0;
    logic [31:0] psw, eipc, eipsw, fepc, fepsw, cause, rpc;
    logic        rvld;

    trap_ret_ctl uut (
        .clk(clk), .rst_n(rst_n),
        .nmi_req_i(nmi_req), .nmi_pc_i(nmi_pc),
        .trap_req_i(trap_req), .trap_vec_i(trap_vec), .trap_pc_i(trap_pc),
        .ret_req_i(ret_req), .irq_off_i(off_req), .irq_on_i(on_req),
        .psw_o(psw), .eipc_o(eipc), .eipsw_o(eipsw), .fepc_o(fepc),
        .fepsw_o(fepsw), .cause_o(cause), .redir_vld_o(rvld), .redir_pc_o(rpc)
    );

    int checks = 0;
    int errors = 0;

    // Reference state (R10 reset values)
    logic [31:0] m_psw = 32'h20, m_eipc = 0, m_eipsw = 0, m_fepc = 0, m_fepsw = 0;
    logic [31:0] m_cause = 0, m_rpc = 0;
    logic        m_rvld = 0;

    task automatic chk(string tag, string fld, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, fld, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "psw", psw, m_psw);
        chk(tag, "eipc", eipc, m_eipc);
        chk(tag, "eipsw", eipsw, m_eipsw);
        chk(tag, "fepc", fepc, m_fepc);
        chk(tag, "fepsw", fepsw, m_fepsw);
        chk(tag, "cause", cause, m_cause);
        chk(tag, "redir_vld", {31'b0, rvld}, {31'b0, m_rvld});
        if (m_rvld) chk(tag, "redir_pc", rpc, m_rpc);
    endtask

    task automatic model_step();
        m_rvld = 0;
        if (nmi_req) begin
            m_fepc = nmi_pc; m_fepsw = m_psw; m_psw = m_psw | 32'hA0;
            m_cause = {16'h0010, m_cause[15:0]};
            m_rvld = 1; m_rpc = 32'h10;
        end else if (trap_req) begin
            m_eipc = trap_pc + 4; m_eipsw = m_psw;
            m_cause = {m_cause[31:16], 16'h40 + 16'(trap_vec)};
            m_psw = m_psw | 32'h60;
            m_rvld = 1; m_rpc = (trap_vec < 16) ? 32'h40 : 32'h50;
        end else if (ret_req) begin
            m_rvld = 1;
            if ((m_psw & 32'hC0) == 32'h80) begin
                m_rpc = m_fepc; m_psw = m_fepsw;
            end else begin
                m_rpc = m_eipc; m_psw = m_eipsw;
            end
        end else if (off_req) m_psw = m_psw | 32'h20;
        else if (on_req) m_psw = m_psw & ~32'h20;
    endtask

    // inputs are set by the caller after a falling edge
    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        #1;
        compare(tag);
        @(negedge clk);
        nmi_req = 0; trap_req = 0; ret_req = 0; off_req = 0; on_req = 0;
    endtask

    task automatic do_trap(string tag, logic [4:0] v, logic [31:0] pc);
        trap_req = 1; trap_vec = v; trap_pc = pc; tick(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R10");
        rst_n = 1;
        tick("R10");
        // R7 enable then disable then both
        on_req = 1; tick("R7");
        off_req = 1; tick("R7");
        off_req = 1; on_req = 1; tick("R7");
        on_req = 1; tick("R7");
        tick("R11");
        // R1 R2 R3 R4 trap vectors at the split boundary
        do_trap("R4", 5'd0, 32'h1000);
        ret_req = 1; tick("R6");
        do_trap("R4", 5'd15, 32'h2000);
        ret_req = 1; tick("R6");
        do_trap("R2", 5'd16, 32'h3000);
        ret_req = 1; tick("R6");
        do_trap("R1", 5'd31, 32'h4004);
        tick("R11");
        ret_req = 1; tick("R6");
        on_req = 1; tick("R7");
        // R8 NMI entry then return through NMI pair
        nmi_req = 1; nmi_pc = 32'h8000; tick("R8");
        ret_req = 1; tick("R5");
        // nested trap inside NMI handler: return uses ordinary pair
        nmi_req = 1; nmi_pc = 32'h9000; tick("R8");
        do_trap("R3", 5'd7, 32'h0100);
        ret_req = 1; tick("R6");
        ret_req = 1; tick("R5");
        // R9 collisions
        trap_req = 1; trap_vec = 5'd20; trap_pc = 32'h500; ret_req = 1; tick("R9");
        nmi_req = 1; nmi_pc = 32'hA000; trap_req = 1; trap_vec = 5'd3; ret_req = 1; tick("R9");
        ret_req = 1; off_req = 1; tick("R9");
        // random mixes
        for (int i = 0; i < 600; i++) begin
            nmi_req  = ($urandom % 16) == 0;
            trap_req = ($urandom % 5) == 0;
            ret_req  = ($urandom % 4) == 0;
            off_req  = ($urandom % 3) == 0;
            on_req   = ($urandom % 3) == 0;
            trap_vec = 5'($urandom);
            trap_pc  = $urandom & 32'hFFFF_FFFC;
            nmi_pc   = $urandom & 32'hFFFF_FFFC;
            tick("R9");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule